// File: doc/BRIEF.md
# Pipelined Sine/Cosine Rotator

This block turns a stream of angles into sine and cosine values with the rotation-mode CORDIC method, unrolled in space. Every iteration is its own hardware stage with its own three adders, a fixed arithmetic right shift equal to the stage index, and a hard-wired arctangent of 2^-i. A register bank closes every stage, so one new angle enters on every clock and each result leaves a fixed number of cycles later.

The first stage is seeded with the constant gain-compensation value (about 0.60725, computed for the chosen stage count) on the cosine path, zero on the sine path, and the input angle on the residual-angle path. Each stage looks at the sign of the residual angle it receives and chooses whether to rotate one way or the other, so the residual shrinks toward zero. A valid bit runs beside the data. There is no quadrant folding, so the caller keeps angles inside [-pi/2, +pi/2]. The block is meant to be used as the phase-to-amplitude stage of a frequency synthesizer, or wherever a sine and a cosine of the same angle are needed at full clock rate.

Angles and results share one signed fixed-point format of DW bits with DW-2 fraction bits: the value is the integer divided by 2^(DW-2). For the default DW = 16, 1.0 is 16384 and pi/2 is about 25736. Internally GUARD extra low bits carry precision, and the outputs drop them by truncation.

Top module: `cordic_rotator_pipe`

## Requirements
- R1: While `rst` is high on a clock edge, and after it as long as no valid angle has been accepted, `out_vld` is 0.
- R2: An angle accepted with `in_vld` = 1 on a clock edge produces `out_vld` = 1 exactly STAGES clock cycles later. With `in_vld` = 0, that later cycle has `out_vld` = 0.
- R3: The block accepts an angle on every clock with no stall. Each accepted angle yields exactly one result, and results come out in the order of acceptance.
- R4: For an angle in [-pi/2, +pi/2], given as a signed DW-bit value with DW-2 fraction bits, `out_cos` and `out_sin` use the same format. Each is within TOL = 6 LSB of round(cos(a) * 2^(DW-2)) and round(sin(a) * 2^(DW-2)) respectively.
- R5: Angle 0 gives `out_cos` within 6 LSB of 2^(DW-2) (16384 for DW = 16) and `out_sin` within 6 LSB of 0.
- R6: Negative angles give a negative sine and a positive cosine within the R4 tolerance, matching sin(-a) = -sin(a) and cos(-a) = cos(a).
- R7: Idle cycles (`in_vld` = 0) between valid angles appear as cycles with `out_vld` = 0 in the same positions of the output stream. They do not disturb neighbouring results.
- R8: A synchronous reset in the middle of a stream discards every angle in flight. No `out_vld` = 1 appears in the STAGES cycles after reset is released unless a new angle was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears all valid bits |
| in_vld | input | 1 | Angle on `in_ang` is accepted on this edge |
| in_ang | input | DW | Signed angle in radians, DW-2 fraction bits |
| out_vld | output | 1 | `out_cos` and `out_sin` hold a result |
| out_cos | output | DW | Signed cosine, DW-2 fraction bits |
| out_sin | output | DW | Signed sine, DW-2 fraction bits |

## Verification
The bench sweeps the whole legal angle range in steps of five LSBs, back to back, and compares every result with a real-valued sine and cosine. A wrong arctangent constant, a wrong shift or an inverted direction decision therefore shows up as errors far beyond the tolerance, mostly near the range ends and for negative angles. Zero and both range ends are applied on their own, because a swapped seed (sine and cosine paths exchanged) or a missing gain factor shows there first. A gapped stream and a reset with data in flight catch a valid pipe that is one stage short or long, that collapses bubbles, or that keeps stale valid bits across reset.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    // Square root by Newton iteration, used only when constants are built.
    function automatic real root_r(input real v);
        real g;
        g = (v > 1.0) ? v : 1.0;
        for (int k = 0; k < 40; k++) begin
            g = 0.5 * (g + v / g);
        end
        return g;
    endfunction

    // Product of 1/sqrt(1 + 2^-2i) over all stages.
    function automatic real gain_r(input int n_stages);
        real acc;
        real p;
        acc = 1.0;
        p   = 1.0;
        for (int i = 0; i < n_stages; i++) begin
            acc = acc / root_r(1.0 + p * p);
            p   = p * 0.5;
        end
        return acc;
    endfunction

    // arctan(2^-i) in radians; power series for i >= 1 where x <= 0.5.
    function automatic real atan_pow2_r(input int i);
        real x;
        real term;
        real sum;
        if (i == 0) begin
            return 0.78539816339744831;
        end
        x = 1.0;
        for (int k = 0; k < i; k++) begin
            x = x * 0.5;
        end
        sum  = 0.0;
        term = x;
        for (int k = 0; k < 40; k++) begin
            if ((k % 2) == 0) begin
                sum = sum + term / real'(2 * k + 1);
            end else begin
                sum = sum - term / real'(2 * k + 1);
            end
            term = term * x * x;
        end
        return sum;
    endfunction

    // Round a non-negative real to an integer with frac fraction bits.
    function automatic int to_fixed(input real v, input int frac);
        real s;
        s = v;
        for (int k = 0; k < frac; k++) begin
            s = s * 2.0;
        end
        return $rtoi(s + 0.5);
    endfunction

endpackage

// File: rtl/cordic_seed.sv
module cordic_seed #(
    parameter int DW    = 16,
    parameter int GUARD = 3,
    parameter int IW    = DW + GUARD,
    parameter int X0    = 0
) (
    input  logic                 vld_i,
    input  logic [DW-1:0]        ang_i,
    output logic                 vld_o,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic signed [IW-1:0] z_o
);
    localparam logic signed [IW-1:0] X_INIT = IW'(X0);

    always_comb begin
        vld_o = vld_i;
        x_o   = X_INIT;
        y_o   = '0;
        z_o   = {ang_i, {GUARD{1'b0}}};
    end
endmodule

// File: rtl/cordic_stage.sv
module cordic_stage #(
    parameter int IW     = 19,
    parameter int SHIFT  = 0,
    parameter int ATAN_C = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vld_i,
    input  logic signed [IW-1:0] x_i,
    input  logic signed [IW-1:0] y_i,
    input  logic signed [IW-1:0] z_i,
    output logic                 vld_o,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic signed [IW-1:0] z_o
);
    localparam logic signed [IW-1:0] ANG = IW'(ATAN_C);

    typedef struct packed {
        logic                 vld;
        logic signed [IW-1:0] x;
        logic signed [IW-1:0] y;
        logic signed [IW-1:0] z;
    } lane_t;

    lane_t st_d;
    lane_t st_q;
    logic signed [IW-1:0] xs;
    logic signed [IW-1:0] ys;

    always_comb begin
        xs      = x_i >>> SHIFT;
        ys      = y_i >>> SHIFT;
        st_d.vld = vld_i;
        if (z_i[IW-1]) begin
            // residual negative: rotate clockwise
            st_d.x = x_i + ys;
            st_d.y = y_i - xs;
            st_d.z = z_i + ANG;
        end else begin
            st_d.x = x_i - ys;
            st_d.y = y_i + xs;
            st_d.z = z_i - ANG;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o = st_q.vld;
    assign x_o   = st_q.x;
    assign y_o   = st_q.y;
    assign z_o   = st_q.z;
endmodule

// File: rtl/cordic_trim.sv
module cordic_trim #(
    parameter int DW    = 16,
    parameter int GUARD = 3,
    parameter int IW    = DW + GUARD
) (
    input  logic                 vld_i,
    input  logic signed [IW-1:0] x_i,
    input  logic signed [IW-1:0] y_i,
    output logic                 vld_o,
    output logic signed [DW-1:0] cos_o,
    output logic signed [DW-1:0] sin_o
);
    always_comb begin
        vld_o = vld_i;
        cos_o = x_i[IW-1:GUARD];
        sin_o = y_i[IW-1:GUARD];
    end
endmodule

// File: rtl/cordic_rotator_pipe.sv
module cordic_rotator_pipe #(
    parameter int DW     = 16,
    parameter int STAGES = 14,
    parameter int GUARD  = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic [DW-1:0]        in_ang,
    output logic                 out_vld,
    output logic signed [DW-1:0] out_cos,
    output logic signed [DW-1:0] out_sin
);
    localparam int IW    = DW + GUARD;
    localparam int FRACW = DW - 2 + GUARD;
    localparam int X0    = cordic_pkg::to_fixed(cordic_pkg::gain_r(STAGES), FRACW);

    logic                 vld_c [STAGES+1];
    logic signed [IW-1:0] x_c   [STAGES+1];
    logic signed [IW-1:0] y_c   [STAGES+1];
    logic signed [IW-1:0] z_c   [STAGES+1];

    cordic_seed #(.DW(DW), .GUARD(GUARD), .IW(IW), .X0(X0)) seed_i (
        .vld_i (in_vld),
        .ang_i (in_ang),
        .vld_o (vld_c[0]),
        .x_o   (x_c[0]),
        .y_o   (y_c[0]),
        .z_o   (z_c[0])
    );

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        localparam int ATAN_I = cordic_pkg::to_fixed(cordic_pkg::atan_pow2_r(i), FRACW);
        cordic_stage #(.IW(IW), .SHIFT(i), .ATAN_C(ATAN_I)) stage_i (
            .clk   (clk),
            .rst   (rst),
            .vld_i (vld_c[i]),
            .x_i   (x_c[i]),
            .y_i   (y_c[i]),
            .z_i   (z_c[i]),
            .vld_o (vld_c[i+1]),
            .x_o   (x_c[i+1]),
            .y_o   (y_c[i+1]),
            .z_o   (z_c[i+1])
        );
    end

    cordic_trim #(.DW(DW), .GUARD(GUARD), .IW(IW)) trim_i (
        .vld_i (vld_c[STAGES]),
        .x_i   (x_c[STAGES]),
        .y_i   (y_c[STAGES]),
        .vld_o (out_vld),
        .cos_o (out_cos),
        .sin_o (out_sin)
    );
endmodule

// File: rtl/cordic_rotator_pipe_chk.sv
module cordic_rotator_pipe_chk #(
    parameter int DW     = 16,
    parameter int STAGES = 14
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_vld,
    input logic                 out_vld,
    input logic signed [DW-1:0] out_cos,
    input logic signed [DW-1:0] out_sin
);
    localparam int     CW  = $clog2(STAGES + 1) + 1;
    localparam longint ONE = longint'(1) << (DW - 2);
    localparam longint LO  = ONE * ONE - 2 * ONE * 16;
    localparam longint HI  = ONE * ONE + 2 * ONE * 16;

    logic [STAGES-1:0] hist_q;
    logic [CW-1:0]     since_q;
    longint            mag;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q  <= '0;
            since_q <= '0;
        end else begin
            hist_q <= {hist_q[STAGES-2:0], in_vld};
            if (since_q < CW'(STAGES)) begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    always_comb begin
        mag = longint'(out_cos) * longint'(out_cos) + longint'(out_sin) * longint'(out_sin);
    end

    // R2 / R7: output valid is the input valid delayed by STAGES cycles
    p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
        out_vld == hist_q[STAGES-1]);

    // R8: nothing valid before a full pipeline depth has passed since reset
    p_no_early_valid_r8: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (since_q >= CW'(STAGES)));

    // R4: the rotation keeps the vector on the unit circle
    p_unit_circle_r4: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (mag > LO && mag < HI));

    // R3: valid output is never unknown
    p_valid_known_r3: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(out_vld));

    // R1: the cycle after a reset edge shows no valid output
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_vld);
endmodule

bind cordic_rotator_pipe cordic_rotator_pipe_chk #(.DW(DW), .STAGES(STAGES)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .out_vld (out_vld),
    .out_cos (out_cos),
    .out_sin (out_sin)
);

// File: tb/cordic_rotator_pipe_tb_top.sv
`timescale 1ns/1ps
module cordic_rotator_pipe_tb_top;
    localparam int DW     = 16;
    localparam int STAGES = 14;
    localparam int ONE    = 1 << (DW - 2);
    localparam int AMAX   = 25735;
    localparam int TOL    = 6;

    typedef struct {
        int    t;
        int    ang;
        string tag;
    } item_t;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_vld = 1'b0;
    logic [DW-1:0]        in_ang = '0;
    logic                 out_vld;
    logic signed [DW-1:0] out_cos;
    logic signed [DW-1:0] out_sin;

    int    cyc = 0;
    int    n_vec = 0;
    int    n_bad = 0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R4";
    item_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cordic_rotator_pipe #(.DW(DW), .STAGES(STAGES)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .in_ang  (in_ang),
        .out_vld (out_vld),
        .out_cos (out_cos),
        .out_sin (out_sin)
    );

    function automatic int ref_val(input int ang, input bit want_sin);
        real a;
        real v;
        a = real'(ang) / real'(ONE);
        v = want_sin ? $sin(a) : $cos(a);
        v = v * real'(ONE);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic send(input bit v, input int ang);
        item_t it;
        @(posedge clk);
        #1;
        in_vld = v;
        in_ang = DW'(ang);
        if (v) begin
            it.t   = cyc;
            it.ang = ang;
            if (ang == 0)     it.tag = "R5";
            else if (ang < 0) it.tag = "R6";
            else              it.tag = cur_tag;
            q.push_back(it);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) send(1'b0, 0);
    endtask

    // Output monitor: order, latency and values
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            if (out_vld) begin
                n_vec++;
                if (q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R3 unexpected valid: actual out_vld=1 expected 0 at cycle %0d", cyc);
                end else begin
                    item_t it;
                    int ec;
                    int es;
                    it = q.pop_front();
                    ec = ref_val(it.ang, 1'b0);
                    es = ref_val(it.ang, 1'b1);
                    if (cyc - it.t != STAGES) begin
                        n_bad++;
                        $display("FAIL R2 latency: actual %0d expected %0d", cyc - it.t, STAGES);
                    end
                    if (iabs(int'(out_cos) - ec) > TOL || iabs(int'(out_sin) - es) > TOL) begin
                        n_bad++;
                        $display("FAIL %s angle %0d: actual cos=%0d sin=%0d expected cos=%0d sin=%0d",
                                 it.tag, it.ang, out_cos, out_sin, ec, es);
                    end
                end
            end else if (q.size() != 0 && q[0].t + STAGES == cyc) begin
                n_vec++;
                n_bad++;
                $display("FAIL R2 missing valid: actual out_vld=0 expected 1 at cycle %0d", cyc);
            end
        end
    end

    task automatic expect_quiet(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            n_vec++;
            if (out_vld !== 1'b0) begin
                n_bad++;
                $display("FAIL %s quiet: actual out_vld=%b expected 0", tag, out_vld);
            end
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(200000.0 * 5.0);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        logic [7:0] lfsr;
        // R1: reset state and idle after reset
        rst = 1'b1;
        expect_quiet(4, "R1");
        @(posedge clk);
        #1 rst = 1'b0;
        expect_quiet(STAGES + 6, "R1");
        mon_on = 1'b1;

        // R4 / R5 / R6 / R3: back-to-back sweep of the legal range
        cur_tag = "R4";
        for (int a = -AMAX; a <= AMAX; a += 5) send(1'b1, a);
        idle(STAGES + 2);

        // R5 and range ends on their own
        send(1'b1, 0);
        idle(3);
        send(1'b1, AMAX);
        send(1'b1, -AMAX);
        send(1'b1, 1);
        send(1'b1, -1);
        idle(STAGES + 2);

        // R7: gapped stream
        cur_tag = "R7";
        lfsr = 8'hA5;
        for (int a = -AMAX; a <= AMAX; a += 97) begin
            while (lfsr[0] & lfsr[3]) begin
                send(1'b0, 0);
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            end
            send(1'b1, a);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
        idle(STAGES + 2);

        // R8: reset with data in flight
        cur_tag = "R8";
        for (int k = 0; k < STAGES / 2; k++) send(1'b1, 1000 * k);
        @(posedge clk);
        #1;
        rst = 1'b1;
        in_vld = 1'b0;
        q.delete();
        @(posedge clk);
        #1 rst = 1'b0;
        expect_quiet(STAGES + 2, "R8");

        // R3: recovery stream after reset, then drain
        cur_tag = "R3";
        for (int a = -20000; a <= 20000; a += 1111) send(1'b1, a);
        idle(STAGES + 3);
        n_vec++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R3 drain: actual %0d pending expected 0", q.size());
        end
        done = 1'b1;
        finish_run();
    end
endmodule